// File: doc/BRIEF.md
# Two-Bank Edge-Latching Interrupt Controller

This block collects 64 interrupt lines, grouped into two banks of 32, and merges them into one interrupt request for the processor. Each line passes through a two-stage synchronizer. A rising edge on a line that is enabled sets a sticky event bit. The event bit stays set until software clears it. The processor's request output is high while any bank holds an event bit whose enable bit is also set.

Software reaches the block through a plain 32-bit register bus: a byte address inside a 64-byte window, a write strobe, write data and combinational read data. Each bank has four words. One word holds the sticky events. One holds the enable mask. One is a write-one-to-clear port. One shows the synchronized state of the lines. The bank for sources 0..31 starts at byte 0x20, and the bank for sources 32..63 starts at byte 0x10. A line that is already high when its enable bit is set raises nothing. Only a later rising edge does.

Top module: `dual_bank_irq_regs`

## Requirements
- R1: After reset every event and enable bit is zero, `irqOut` is low and every register reads zero while all sources are low.
- R2: Source n belongs to bank n>>5 at bit n&31, with data bit i carrying bit i of the bank (little-endian). Bank 0 (sources 0..31) has its base at byte 0x20 and bank 1 (sources 32..63) at byte 0x10. Inside a bank the words are: event at +0x0, enable at +0x4, clear at +0x8, line state at +0xC.
- R3: The enable word reads back exactly the value last written to it.
- R4: A rising edge on an enabled source sets its event bit on the third clock edge after the input changes. An edge on a disabled source sets nothing.
- R5: Setting an enable bit while its source is already high sets no event bit and leaves `irqOut` low.
- R6: Writing 1 to a bit of the clear word resets the matching event bit. A 0 in the written data leaves that event bit as it was.
- R7: The line-state word shows each source after the two-flop synchronizer, whatever the enable mask holds. A change is visible two clock edges after the input moves, and not after one.
- R8: `irqOut` is the OR over both banks of event AND enable. Clearing an enable bit drops the request but keeps the event bit.
- R9: An event bit stays set after its source falls, until it is cleared.
- R10: The clear word reads zero. Writes to the event word, the line-state word, bytes 0x00..0x0F and 0x30..0x3F, or any address with nonzero low two bits change nothing, and those unmapped addresses read zero.
- R11: When a new rising edge and a clear of the same event bit land in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 64 | Raw interrupt source lines, bit n is source n |
| busAddr | input | 6 | Byte address inside the register window |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume the bus presents at most one write per cycle and that `busWdata` is valid whenever `busWe` is high. They also assume that `srcIn` is free to change at any cycle, because every history check looks only at synchronized values. The stimulus changes sources and bus signals only on falling clock edges and keeps each write strobe one cycle wide. It lines up each clear with the edge pipeline when it needs a same-cycle collision. Every source pattern is held for at least three cycles, so the synchronizer output settles before any event is checked.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_CLEAR  = 2'd2,
    REG_LEVEL  = 2'd3
  } regSel_e;

  // Strobes passed from the address decoder to the datapath.
  typedef struct packed {
    logic       hit;
    logic       wrEnable;
    logic       wrClear;
    regSel_e    sel;
    logic [7:0] bank;
  } busStrobe_t;

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrobe_t        strb
);

  localparam int BLK_W = ADDR_W - 4;

  // Bank b has its base at 16*(NUM_BANKS-b): 0x20 for bank 0, 0x10 for bank 1.
  always_comb begin
    strb      = '0;
    strb.sel  = regSel_e'(busAddr[3:2]);
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (busAddr[ADDR_W-1:4] == BLK_W'(NUM_BANKS - b) && busAddr[1:0] == 2'b00) begin
        strb.hit  = 1'b1;
        strb.bank = 8'(b);
      end
    end
    strb.wrEnable = strb.hit && busWe && (strb.sel == REG_ENABLE);
    strb.wrClear  = strb.hit && busWe && (strb.sel == REG_CLEAR);
  end

  AST_WR_UNMAPPED: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (busAddr[ADDR_W-1:4] == '0 || busAddr[1:0] != 2'b00)) |-> !(strb.wrEnable || strb.wrClear)); // R10

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int BANK_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_BANKS*BANK_W-1:0]   srcIn,
  input  busStrobe_t                    strb,
  input  logic [BANK_W-1:0]             wrData,
  output logic [BANK_W-1:0]             rdData,
  output logic                          irqOut
);

  localparam int NUM_SRC = NUM_BANKS * BANK_W;

  logic [SYNC_STAGES-1:0][NUM_SRC-1:0] syncPipe;
  logic [NUM_SRC-1:0]                  syncLast;
  logic [NUM_SRC-1:0]                  levelVec;
  logic [NUM_SRC-1:0]                  riseVec;

  logic [NUM_BANKS-1:0][BANK_W-1:0] levelB;
  logic [NUM_BANKS-1:0][BANK_W-1:0] riseB;
  logic [NUM_BANKS-1:0][BANK_W-1:0] eventQ;
  logic [NUM_BANKS-1:0][BANK_W-1:0] enableQ;
  logic [NUM_BANKS-1:0][BANK_W-1:0] clearMask;
  logic [NUM_BANKS-1:0]             enableHit;

  // Synchronizer chain, followed by one more stage for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
      syncLast <= '0;
    end else begin
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], srcIn};
      syncLast <= syncPipe[SYNC_STAGES-1];
    end
  end

  assign levelVec = syncPipe[SYNC_STAGES-1];
  assign riseVec  = levelVec & ~syncLast;
  assign levelB   = levelVec;
  assign riseB    = riseVec;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      enableHit[b] = strb.wrEnable && (strb.bank == 8'(b));
      clearMask[b] = (strb.wrClear && (strb.bank == 8'(b))) ? wrData : '0;
    end
  end

  // A set from a new edge takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventQ  <= '0;
      enableQ <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        eventQ[b] <= (eventQ[b] & ~clearMask[b]) | (riseB[b] & enableQ[b]);
        if (enableHit[b]) enableQ[b] <= wrData;
      end
    end
  end

  always_comb begin
    irqOut = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) irqOut = irqOut | (|(eventQ[b] & enableQ[b]));
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strb.hit && strb.bank == 8'(b)) begin
        unique case (strb.sel)
          REG_EVENT:  rdData = eventQ[b];
          REG_ENABLE: rdData = enableQ[b];
          REG_LEVEL:  rdData = levelB[b];
          REG_CLEAR:  rdData = '0;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gChk
    AST_EVENT_FROM_EDGE: assert property (@(posedge clk) disable iff (!rstN)
      ((eventQ[g] & ~$past(eventQ[g])) & ~$past(riseB[g] & enableQ[g])) == '0); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      (eventQ[g] & $past(clearMask[g] & ~(riseB[g] & enableQ[g]))) == '0); // R6
    AST_EVENT_HELD: assert property (@(posedge clk) disable iff (!rstN)
      ($past(eventQ[g]) & ~$past(clearMask[g]) & ~eventQ[g]) == '0); // R9
    AST_ENABLE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
      $past(enableHit[g]) |-> (enableQ[g] == $past(wrData))); // R3
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|enableQ)); // R8

endmodule

// File: rtl/dual_bank_irq_regs.sv
module dual_bank_irq_regs
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int BANK_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_BANKS*BANK_W-1:0] srcIn,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWe,
  input  logic [BANK_W-1:0]           busWdata,
  output logic [BANK_W-1:0]           busRdata,
  output logic                        irqOut
);

  busStrobe_t strb;

  irqc_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWe  (busWe),
    .strb   (strb)
  );

  irqc_datapath #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_W     (BANK_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk   (clk),
    .rstN  (rstN),
    .srcIn (srcIn),
    .strb  (strb),
    .wrData(busWdata),
    .rdData(busRdata),
    .irqOut(irqOut)
  );

endmodule

// File: tb/sim_dual_bank_irq_regs.sv
`timescale 1ns/1ps
module sim_dual_bank_irq_regs;

  localparam logic [5:0] EV0 = 6'h20, EN0 = 6'h24, CL0 = 6'h28, LV0 = 6'h2C;
  localparam logic [5:0] EV1 = 6'h10, EN1 = 6'h14, CL1 = 6'h18, LV1 = 6'h1C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcIn = '0;
  logic [5:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;

  dual_bank_irq_regs u0 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // Monitor: compares queued expectations midway between edges.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        act = it.isIrq ? {31'b0, irqOut} : busRdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setSrc(logic [63:0] v);
    @(negedge clk);
    srcIn = v;
  endtask

  task automatic busWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr  = a;
    busWdata = d;
    busWe    = 1'b1;
    @(posedge clk);
    #1 busWe = 1'b0;
  endtask

  task automatic expRead(logic [5:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    busAddr = a;
    expQ.push_back('{1'b0, e, tag});
  endtask

  task automatic expIrq(logic e, string tag);
    @(negedge clk);
    expQ.push_back('{1'b1, {31'b0, e}, tag});
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;

    // R1 reset state
    expRead(EV0, 32'h0, "R1 ev0"); expRead(EV1, 32'h0, "R1 ev1");
    expRead(EN0, 32'h0, "R1 en0"); expRead(EN1, 32'h0, "R1 en1");
    expRead(LV0, 32'h0, "R1 lv0"); expRead(LV1, 32'h0, "R1 lv1");
    expIrq(1'b0, "R1 irq");

    // R3 enable readback
    busWrite(EN0, 32'h0000_0005);
    busWrite(EN1, 32'h8000_0001);
    expRead(EN0, 32'h0000_0005, "R3 en0");
    expRead(EN1, 32'h8000_0001, "R3 en1");

    // R7 sync depth, R4 enabled versus disabled edges, R8 request
    setSrc(64'h0000_0001_0000_0003);
    expRead(LV0, 32'h0, "R7 lv0 one edge");
    expRead(LV0, 32'h3, "R7 lv0 two edges");
    expRead(LV1, 32'h1, "R7 lv1");
    expRead(EV0, 32'h1, "R4 ev0 disabled bit1 ignored");
    expRead(EV1, 32'h1, "R4 ev1");
    expIrq(1'b1, "R8 irq set");

    // R9 events are sticky after the source falls
    setSrc(64'h0);
    idle(3);
    expRead(EV0, 32'h1, "R9 ev0 held");
    expRead(LV0, 32'h0, "R7 lv0 low");

    // R6 write-one-to-clear
    busWrite(CL0, 32'h0);
    expRead(EV0, 32'h1, "R6 zero write keeps");
    busWrite(CL0, 32'h1);
    expRead(EV0, 32'h0, "R6 one write clears");
    expIrq(1'b1, "R8 bank1 still pending");
    busWrite(CL1, 32'h1);
    expIrq(1'b0, "R8 all clear");

    // R5 enabling a line that is already high
    setSrc(64'h10);
    idle(3);
    busWrite(EN0, 32'h15);
    idle(2);
    expRead(EV0, 32'h0, "R5 no event");
    expIrq(1'b0, "R5 no irq");
    expRead(EN0, 32'h15, "R3 en0 new");

    // R8 masking keeps the event
    setSrc(64'h0);
    idle(3);
    setSrc(64'h10);
    idle(3);
    expRead(EV0, 32'h10, "R4 ev0 bit4");
    expIrq(1'b1, "R8 irq bit4");
    busWrite(EN0, 32'h5);
    expIrq(1'b0, "R8 masked");
    expRead(EV0, 32'h10, "R8 event kept");
    busWrite(CL0, 32'h10);
    expRead(EV0, 32'h0, "R6 bit4 cleared");

    // R10 read-only, write-only and unmapped locations
    busWrite(EV0, 32'hFFFF_FFFF);
    expRead(EV0, 32'h0, "R10 event write ignored");
    busWrite(LV1, 32'hFFFF_FFFF);
    expRead(LV1, 32'h0, "R10 level write ignored");
    expRead(LV0, 32'h10, "R7 level with bit disabled");
    expRead(CL0, 32'h0, "R10 clear reads zero");
    busWrite(6'h04, 32'hFFFF_FFFF);
    busWrite(6'h34, 32'hFFFF_FFFF);
    busWrite(6'h25, 32'hFFFF_FFFF);
    expRead(6'h04, 32'h0, "R10 low hole");
    expRead(6'h34, 32'h0, "R10 high hole");
    expRead(6'h26, 32'h0, "R10 misaligned read");
    expRead(EN0, 32'h5, "R10 en0 untouched");
    expRead(EN1, 32'h8000_0001, "R10 en1 untouched");

    // R11 same-cycle edge and clear
    setSrc(64'h1);
    idle(2);
    expRead(EV0, 32'h1, "R4 ev0 bit0");
    setSrc(64'h0);
    idle(3);
    setSrc(64'h1);
    idle(1);
    busWrite(CL0, 32'h1);
    expRead(EV0, 32'h1, "R11 set wins");
    expIrq(1'b1, "R11 irq");
    setSrc(64'h0);
    idle(3);
    busWrite(CL0, 32'h1);
    expRead(EV0, 32'h0, "R6 plain clear");

    // R2 top bit mapping in both banks
    setSrc(64'h8000_0000_8000_0000);
    idle(3);
    expRead(LV0, 32'h8000_0000, "R2 lv0 bit31");
    expRead(LV1, 32'h8000_0000, "R2 lv1 bit31");
    expRead(EV0, 32'h0, "R2 ev0 bit31 disabled");
    expRead(EV1, 32'h8000_0000, "R2 ev1 source63");
    expIrq(1'b1, "R2 irq");

    idle(2);
    finished = 1;
    finishRun();
  end

endmodule